// File: doc/BRIEF.md
# Vectored Critical Interrupt Controller

This block gathers 32 interrupt inputs into one status word and drives two request lines toward a processor: a normal one and a critical one. Each input can be set to latch on a rising edge or to follow its level. A separate mask decides which sources take part, and a routing mask decides which of the two lines each source drives. Software reaches nine word registers through a simple strobe interface. Each register has an address offset, a write strobe, a read strobe and 32-bit data.

When a critical request is active, the block also offers a ready-made handler address. This address is a programmable base plus a 512-byte step for each priority position. A configuration bit chooses whether priority runs from input 0 or from input 31. A source that is level-sensitive and still asserted cannot be cleared by software. The vector and vector-configuration registers can be removed with a parameter; they then read as zero.

Top module: `crit_vec_intc`

## Requirements
- R1: After reset every register reads zero, and both `irq_norm` and `irq_crit` are low.
- R2: Input `irq_in[n]` is reflected in register bit 31-n, so input 0 occupies bit 31.
- R3: A source whose trigger bit (offset 5) is 1 sets its status bit on a 0-to-1 input transition. The bit stays set after the input falls.
- R4: A source whose trigger bit is 0 is level-sensitive: its status bit takes the input value whenever the input changes. A level-hold bit tracks the same value.
- R5: Writing offset 0 clears each status bit written as 1. Bits whose level-hold is set stay set.
- R6: Writing offset 1 ORs the data into status. Reading offset 0 or offset 1 returns status.
- R7: Reading offset 6 returns status AND enable (offset 2). Writes to offsets 6 and 7 change nothing.
- R8: `irq_norm` is high when status AND enable AND NOT critical-select (offset 3) is nonzero. `irq_crit` is high when status AND enable AND critical-select is nonzero.
- R9: When bit 0 of the vector configuration (offset 8) is 0 and a critical source is pending, offset 7 reads (configuration with bits 1:0 cleared) + 512·i. Here i is the lowest-numbered pending critical bit.
- R10: When configuration bit 0 is 1, offset 7 reads (configuration with bits 1:0 cleared) + 512·(31−i). Here i is the highest-numbered pending critical bit.
- R11: Offset 7 reads zero while no critical source is pending. A write to offset 8 stores the data with bit 1 forced to 0.
- R12: The polarity register (offset 4) reads back what was written and does not change status. Offsets 9 to 15 read zero.
- R13: A status bit's input event in a cycle takes precedence over a software clear of that bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; inputs are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Interrupt source lines, index n maps to bit 31-n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is zero when low |
| addr | input | 4 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
A software clear of a status bit and a hardware input event on that same bit can fall in one clock cycle. The bench raises an edge-sensitive input on the same falling edge where it issues a clear write to the matching bit. It then expects the bit to read back as set. The same clear is then repeated with the input held steady, and the bit must now read back cleared. This shows that the set seen earlier came from the input event and not from a clear path that failed to work.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned W  = 32;
  localparam int unsigned AW = 4;

  localparam logic [AW-1:0] A_STAT = 4'd0;
  localparam logic [AW-1:0] A_SSET = 4'd1;
  localparam logic [AW-1:0] A_ENA  = 4'd2;
  localparam logic [AW-1:0] A_CSEL = 4'd3;
  localparam logic [AW-1:0] A_POL  = 4'd4;
  localparam logic [AW-1:0] A_TRIG = 4'd5;
  localparam logic [AW-1:0] A_MSK  = 4'd6;
  localparam logic [AW-1:0] A_VEC  = 4'd7;
  localparam logic [AW-1:0] A_VCFG = 4'd8;

  // input n lands on bit W-1-n
  function automatic logic [W-1:0] map_inputs(input logic [W-1:0] raw);
    logic [W-1:0] m;
    for (int i = 0; i < W; i++) m[W-1-i] = raw[i];
    return m;
  endfunction

  // handler address for a nonzero pending-critical word
  function automatic logic [W-1:0] vec_calc(input logic [W-1:0] pend,
                                            input logic [W-1:0] cfg,
                                            input int unsigned  step_lg2);
    logic [W-1:0] pos;
    pos = '0;
    if (cfg[0]) begin
      for (int i = 0; i < W; i++)
        if (pend[i]) pos = W - 1 - i;       // last hit is the highest bit
    end else begin
      for (int i = W - 1; i >= 0; i--)
        if (pend[i]) pos = i;               // last hit is the lowest bit
    end
    return {cfg[W-1:2], 2'b00} + (pos << step_lg2);
  endfunction
endpackage

// File: rtl/vic_srcs.sv
module vic_srcs
  import vic_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] irq_raw,
  input  logic [W-1:0] trig,
  input  logic         clr_we,
  input  logic         set_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] status,
  output logic [W-1:0] level_q
);
  logic [W-1:0] in_m, in_q, chg, rise, lvl_evt, sw_next, nxt;

  assign in_m    = map_inputs(irq_raw);
  assign chg     = in_m ^ in_q;
  assign rise    = in_m & ~in_q & trig;
  assign lvl_evt = chg & ~trig;

  always_comb begin
    sw_next = status;
    if (clr_we) sw_next = (status & ~wdata) | level_q;
    if (set_we) sw_next = sw_next | wdata;
    // input events are applied last and so win over software
    nxt = ((sw_next | rise) & ~lvl_evt) | (in_m & lvl_evt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q    <= '0;
      status  <= '0;
      level_q <= '0;
    end else begin
      in_q    <= in_m;
      status  <= nxt;
      level_q <= (level_q & ~lvl_evt) | (in_m & lvl_evt);
    end
  end

  a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((status & $past(rise)) == $past(rise)));

  a_r4_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_evt) |=> (((status ^ $past(in_m)) & $past(lvl_evt)) == '0));

  a_r5_clear_keeps_held: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !(|chg)) |=> ((status & $past(wdata) & ~$past(level_q)) == '0));

  a_r6_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
    (set_we && !(|lvl_evt)) |=> ((status & $past(wdata)) == $past(wdata)));

  a_r13_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (|(rise & wdata))) |=> ((status & $past(rise)) == $past(rise)));
endmodule

// File: rtl/vic_vec.sv
module vic_vec
  import vic_pkg::*;
#(
  parameter int unsigned STEP_LG2 = 9
) (
  input  logic [W-1:0] pend_crit,
  input  logic [W-1:0] cfg,
  output logic [W-1:0] vec
);
  assign vec = (|pend_crit) ? vec_calc(pend_crit, cfg, STEP_LG2) : '0;
endmodule

// File: rtl/crit_vec_intc.sv
module crit_vec_intc
  import vic_pkg::*;
#(
  parameter bit          HAS_VEC  = 1'b1,
  parameter int unsigned STEP_LG2 = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  irq_in,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic          irq_norm,
  output logic          irq_crit
);
  logic [W-1:0] status, level_q, ena_q, csel_q, pol_q, trig_q, vcfg_q, vec_val;
  logic [W-1:0] live, crit_pend;
  logic         we_clr, we_set;

  assign we_clr = wr_en && (addr == A_STAT);
  assign we_set = wr_en && (addr == A_SSET);

  vic_srcs u_srcs (
    .clk(clk), .rst_n(rst_n), .irq_raw(irq_in), .trig(trig_q),
    .clr_we(we_clr), .set_we(we_set), .wdata(wdata),
    .status(status), .level_q(level_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ena_q  <= '0;
      csel_q <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (wr_en) begin
      if (addr == A_ENA)  ena_q  <= wdata;
      if (addr == A_CSEL) csel_q <= wdata;
      if (addr == A_POL)  pol_q  <= wdata;
      if (addr == A_TRIG) trig_q <= wdata;
    end
  end

  assign live      = status & ena_q;
  assign crit_pend = live & csel_q;
  assign irq_norm  = |(live & ~csel_q);
  assign irq_crit  = |crit_pend;

  generate
    if (HAS_VEC) begin : g_vec
      always_ff @(posedge clk) begin
        if (!rst_n)                        vcfg_q <= '0;
        else if (wr_en && addr == A_VCFG)  vcfg_q <= wdata & ~32'h2;
      end
      vic_vec #(.STEP_LG2(STEP_LG2)) u_vec (
        .pend_crit(crit_pend), .cfg(vcfg_q), .vec(vec_val)
      );

      a_r11_cfg_bit1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_VCFG) |=> (vcfg_q[1] == 1'b0 &&
                                       vcfg_q[W-1:2] == $past(wdata[W-1:2])));
    end else begin : g_novec
      assign vcfg_q  = '0;
      assign vec_val = '0;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        A_STAT, A_SSET: rdata = status;
        A_ENA:          rdata = ena_q;
        A_CSEL:         rdata = csel_q;
        A_POL:          rdata = pol_q;
        A_TRIG:         rdata = trig_q;
        A_MSK:          rdata = live;
        A_VEC:          rdata = vec_val;
        A_VCFG:         rdata = vcfg_q;
        default:        rdata = '0;
      endcase
    end
  end

  a_r11_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_crit |-> (vec_val == '0));

  a_r9_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    irq_crit |-> (vec_val[1:0] == 2'b00));

  a_r7_msk_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_MSK || addr == A_VEC)) |=>
      ($stable(ena_q) && $stable(csel_q) && $stable(trig_q) && $stable(pol_q)));

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_norm && !irq_crit));
endmodule

// File: tb/sim_crit_vec_intc.sv
module sim_crit_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_norm, irq_crit;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  crit_vec_intc u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_norm(irq_norm), .irq_crit(irq_crit)
  );

  function automatic logic [31:0] vec_ref(input logic [31:0] p, input logic [31:0] cfg);
    int i;
    if (p == 0) return 32'h0;
    if (cfg[0]) begin
      i = 31;
      while (!p[i]) i--;
      return (cfg & 32'hFFFF_FFFC) + (31 - i) * 512;
    end
    i = 0;
    while (!p[i]) i++;
    return (cfg & 32'hFFFF_FFFC) + i * 512;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    rd_en = 1'b1; addr = a;
    #1;
    chk(req, rdata, exp);
    rd_en = 1'b0;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 9; a++) rd_chk("R1", 4'(a), 32'h0);
    chk("R1 outs", {30'h0, irq_norm, irq_crit}, 32'h0);
  endtask

  task automatic t_edge;
    wr(4'd5, 32'hFFFF_FFFF);
    drive(32'h1);
    rd_chk("R2 R3 rise", 4'd0, 32'h8000_0000);
    drive(32'h0);
    rd_chk("R3 sticky", 4'd0, 32'h8000_0000);
    wr(4'd0, 32'h8000_0000);
    rd_chk("R5 clear edge", 4'd0, 32'h0);
  endtask

  task automatic t_level;
    wr(4'd5, ~32'h1000_0000);
    drive(32'h8);
    rd_chk("R4 follow high", 4'd0, 32'h1000_0000);
    wr(4'd0, 32'hFFFF_FFFF);
    rd_chk("R5 held", 4'd0, 32'h1000_0000);
    drive(32'h0);
    rd_chk("R4 follow low", 4'd0, 32'h0);
  endtask

  task automatic t_set;
    wr(4'd1, 32'h00F0_0000);
    rd_chk("R6 off0", 4'd0, 32'h00F0_0000);
    rd_chk("R6 off1", 4'd1, 32'h00F0_0000);
    wr(4'd0, 32'h00F0_0000);
    rd_chk("R5 clear set", 4'd0, 32'h0);
  endtask

  task automatic t_mask;
    wr(4'd1, 32'h3);
    wr(4'd2, 32'h1);
    rd_chk("R7 masked", 4'd6, 32'h1);
    chk("R8 norm only", {30'h0, irq_norm, irq_crit}, 32'h2);
    wr(4'd6, 32'hFFFF_FFFF);
    rd_chk("R7 msk wr ignored", 4'd6, 32'h1);
    rd_chk("R7 ena kept", 4'd2, 32'h1);
    wr(4'd7, 32'h0000_FFFF);
    rd_chk("R7 vec wr ignored", 4'd7, 32'h0);
    wr(4'd2, 32'h3);
    wr(4'd3, 32'h2);
    chk("R8 both", {30'h0, irq_norm, irq_crit}, 32'h3);
    wr(4'd3, 32'h3);
    chk("R8 crit only", {30'h0, irq_norm, irq_crit}, 32'h1);
  endtask

  task automatic t_vec;
    wr(4'd8, 32'h0001_0002);
    rd_chk("R11 cfg bit1", 4'd8, 32'h0001_0000);
    rd_chk("R9 asc low", 4'd7, vec_ref(32'h3, 32'h0001_0000));
    wr(4'd3, 32'h2);
    rd_chk("R9 asc bit1", 4'd7, vec_ref(32'h2, 32'h0001_0000));
    wr(4'd8, 32'h0002_0003);
    rd_chk("R10 desc", 4'd7, vec_ref(32'h2, 32'h0002_0001));
    chk("R10 desc value", vec_ref(32'h2, 32'h0002_0001), 32'h0002_3C00);
    wr(4'd1, 32'h8000_0000);
    wr(4'd2, 32'h8000_0003);
    wr(4'd3, 32'h8000_0002);
    rd_chk("R10 desc top", 4'd7, 32'h0002_0000);
    wr(4'd8, 32'h0002_0000);
    rd_chk("R9 asc mixed", 4'd7, 32'h0002_0200);
    wr(4'd3, 32'h0);
    chk("R11 crit low", {31'h0, irq_crit}, 32'h0);
    rd_chk("R11 vec zero", 4'd7, 32'h0);
  endtask

  task automatic t_pol;
    wr(4'd4, 32'hA5A5_A5A5);
    rd_chk("R12 pol", 4'd4, 32'hA5A5_A5A5);
    rd_chk("R12 status", 4'd0, 32'h8000_0003);
    rd_chk("R12 off9", 4'd9, 32'h0);
    rd_chk("R12 off15", 4'd15, 32'h0);
  endtask

  task automatic t_race;
    wr(4'd5, 32'hFFFF_FFFF);
    wr(4'd0, 32'hFFFF_FFFF);
    rd_chk("R5 wipe", 4'd0, 32'h0);
    @(negedge clk);
    irq_in = 32'h20; wr_en = 1'b1; addr = 4'd0; wdata = 32'h0400_0000;
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk("R13 event wins", 4'd0, 32'h0400_0000);
    wr(4'd0, 32'h0400_0000);
    rd_chk("R13 later clear", 4'd0, 32'h0);
  endtask

  task automatic finish_up;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge();
    t_level();
    t_set();
    t_mask();
    t_vec();
    t_pol();
    t_race();
    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      finish_up();
    end
  end
endmodule